// File: doc/BRIEF.md
# Shared-Counter Multi-Channel Event Timer

The block contains one free-running 64-bit main counter and a set of comparator channels that all watch it. Each channel compares the counter against its own match point. On a hit it sets a status bit, or emits a one-cycle pulse, and it drives its own interrupt line. Software arms a channel only by writing that channel's comparator. The shared counter is never rewritten to schedule an event, because that would shift every other channel.

A channel can run in one-shot mode, or in periodic mode if it was built with that capability. In periodic mode a value-set flag sends the first comparator write to the match point and the following write to a hidden period register. After every hit the match point advances by that period. A channel can also be forced into 32-bit operation: it keeps only the low half of its comparator and compares only the low half of the counter.

Access is through a simple word-wide register port. A read returns data one cycle after the request.

Top module: `evt_timer`

## Requirements
- R1: The read-only capability word at byte address 0x000 holds the channel count minus one in bits [4:0]. Bit 8 is 1 to mark a 64-bit counter, and bits [63:32] hold the tick period in femtoseconds. Bits 7:5 and 31:9 are zero.
- R2: After reset the counter reads 0. It advances by exactly one per clock while bit 0 of the global control word (0x008) is 1, and it holds its value while that bit is 0.
- R3: A write to the counter word (0x018) loads it only while counting is stopped. The same write while counting is ignored.
- R4: In one-shot mode, a counter value equal to the comparator while counting sets the channel's status bit on the following clock. It fires once, and the channel is re-armed by writing a new comparator value.
- R5: In the status word (0x010), channel i owns bit i. Writing 1 there clears it and writing 0 leaves it. A hit on the same clock as a clearing write leaves the bit set.
- R6: In level mode (channel config bit 1 = 1), the interrupt equals status AND interrupt enable (config bit 0). The status bit is set on a hit even when the enable is 0.
- R7: In edge mode (config bit 1 = 0), a hit with the enable set gives an interrupt pulse exactly one clock long, and the status bit is not set.
- R8: On a periodic-capable channel with the periodic bit (config bit 2) and the value-set bit (config bit 3) set, the next comparator write sets the first match point and the write after it sets the period. After each hit the match point grows by the period. The value-set bit reads 0 once its write has been taken.
- R9: Config bit 5 is a read-only capability flag. A channel without it reads the periodic and value-set bits as 0 and behaves one-shot, so every comparator write sets its match point.
- R10: With config bit 4 set, a comparator write keeps only its low 32 bits (the upper half reads 0), and a hit needs only the counter's low 32 bits to match.
- R11: Channel i's config word sits at 0x100 + 0x20·i and its comparator at 0x108 + 0x20·i. Read data appears on the clock after the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Byte address, 8-byte aligned |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, registered |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
Two functions can land on the same clock edge: a channel's hit setting its status bit, and a software write clearing that bit. The bench starts the counter from zero at a known edge and counts cycles, so that the write-one-to-clear reaches the status word on exactly the edge where the counter equals the comparator. The interrupt line must then stay high, showing that the set takes priority. A second collision of the same kind is a comparator readback right after a periodic advance, which must show the moved match point.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int DATA_W   = 64;
    localparam int ADDR_W   = 10;
    localparam int CHIDX_W  = 3;

    localparam logic [ADDR_W-1:0] A_CAP  = 10'h000;
    localparam logic [ADDR_W-1:0] A_GCFG = 10'h008;
    localparam logic [ADDR_W-1:0] A_STAT = 10'h010;
    localparam logic [ADDR_W-1:0] A_CNT  = 10'h018;

    // channel config, bits [4:0] of the config word
    typedef struct packed {
        logic f32;   // bit 4: force 32-bit compare
        logic vset;  // bit 3: next comparator write is the first match point
        logic per;   // bit 2: periodic
        logic lvl;   // bit 1: level (1) / edge (0)
        logic ie;    // bit 0: interrupt enable
    } ch_cfg_t;

    function automatic logic [DATA_W-1:0] cfg_word(ch_cfg_t c, logic cap);
        return {{(DATA_W-6){1'b0}}, cap, c};
    endfunction

    function automatic logic [DATA_W-1:0] low_half(logic [DATA_W-1:0] v);
        return {{(DATA_W-32){1'b0}}, v[31:0]};
    endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (run)  cnt <= cnt + 1'b1;
        else if (load) cnt <= load_val;
    end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit PER_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [DATA_W-1:0] cnt,
    input  logic              cfg_we,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stat_clr,
    output logic [DATA_W-1:0] cfg_rd,
    output logic [DATA_W-1:0] cmp_rd,
    output logic              stat,
    output logic              hit,
    output logic              irq
);
    ch_cfg_t           cfg, cfg_in;
    logic [DATA_W-1:0] cmp, period, cmp_in, adv;
    logic              per_next;
    logic              pulse;

    always_comb begin
        cfg_in = ch_cfg_t'(wdata[4:0]);
        if (!PER_CAP) begin
            cfg_in.per  = 1'b0;
            cfg_in.vset = 1'b0;
        end
        cmp_in = cfg.f32 ? low_half(wdata) : wdata;
        adv    = cfg.f32 ? low_half(cmp + period) : cmp + period;
        hit    = run && (cfg.f32 ? (cnt[31:0] == cmp[31:0]) : (cnt == cmp));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            cmp      <= '0;
            period   <= '0;
            per_next <= 1'b0;
        end else if (cfg_we) begin
            cfg <= cfg_in;
        end else if (cmp_we) begin
            cfg.vset <= 1'b0;
            if (per_next) begin
                period   <= cmp_in;
                per_next <= 1'b0;
            end else begin
                cmp <= cmp_in;
                if (cfg.vset && cfg.per) per_next <= 1'b1;
            end
        end else if (hit && cfg.per) begin
            cmp <= adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            if (hit && cfg.lvl)  stat <= 1'b1;
            else if (stat_clr)   stat <= 1'b0;
            pulse <= hit && !cfg.lvl && cfg.ie;
        end
    end

    assign irq    = cfg.lvl ? (stat && cfg.ie) : pulse;
    assign cfg_rd = cfg_word(cfg, PER_CAP);
    assign cmp_rd = cmp;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int                 NUM_CH       = 3,
    parameter logic [NUM_CH-1:0]  PER_CAP_MASK = 3'b011,
    parameter logic [31:0]        TICK_FS      = 32'd10_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_CH-1:0]   irq
);
    localparam logic [4:0]        NCH_M1   = 5'(NUM_CH - 1);
    localparam logic [DATA_W-1:0] CAP_WORD = {TICK_FS, 23'b0, 1'b1, 3'b0, NCH_M1};

    logic                gen_en;
    logic [DATA_W-1:0]   cnt_q;
    logic [NUM_CH-1:0]   stat_v, ch_hit;
    logic [DATA_W-1:0]   cfg_a [NUM_CH];
    logic [DATA_W-1:0]   cmp_a [NUM_CH];
    logic                is_ch, ch_reg;
    logic [CHIDX_W-1:0]  ch_idx;
    logic [DATA_W-1:0]   rd_mux;

    assign is_ch  = (addr[9:8] == 2'b01) && !addr[4] && (addr[2:0] == 3'b000);
    assign ch_idx = addr[7:5];
    assign ch_reg = addr[3];

    always_ff @(posedge clk) begin
        if (rst)                          gen_en <= 1'b0;
        else if (wr_en && addr == A_GCFG) gen_en <= wdata[0];
    end

    evt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (gen_en),
        .load     (wr_en && addr == A_CNT),
        .load_val (wdata),
        .cnt      (cnt_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = wr_en && is_ch && (ch_idx == CHIDX_W'(i));
        evt_channel #(.PER_CAP(PER_CAP_MASK[i])) u_ch (
            .clk      (clk),
            .rst      (rst),
            .run      (gen_en),
            .cnt      (cnt_q),
            .cfg_we   (sel && !ch_reg),
            .cmp_we   (sel && ch_reg),
            .wdata    (wdata),
            .stat_clr (wr_en && addr == A_STAT && wdata[i]),
            .cfg_rd   (cfg_a[i]),
            .cmp_rd   (cmp_a[i]),
            .stat     (stat_v[i]),
            .hit      (ch_hit[i]),
            .irq      (irq[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (is_ch) begin
            for (int i = 0; i < NUM_CH; i++)
                if (ch_idx == CHIDX_W'(i)) rd_mux = ch_reg ? cmp_a[i] : cfg_a[i];
        end else begin
            case (addr)
                A_CAP:   rd_mux = CAP_WORD;
                A_GCFG:  rd_mux = DATA_W'(gen_en);
                A_STAT:  rd_mux = DATA_W'(stat_v);
                A_CNT:   rd_mux = cnt_q;
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                gen_en,
    input logic [DATA_W-1:0]   cnt,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [NUM_CH-1:0]   stat,
    input logic [NUM_CH-1:0]   hit
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        gen_en |=> cnt == $past(cnt) + 1'b1);  // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!gen_en && !(wr_en && addr == A_CNT)) |=> cnt == $past(cnt));  // R2
    AST_CNT_WR_LOCK: assert property (@(posedge clk) disable iff (rst)
        (gen_en && wr_en && addr == A_CNT) |=> cnt == $past(cnt) + 1'b1);  // R3

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        AST_STAT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
            $rose(stat[i]) |-> $past(gen_en));  // R4
        AST_STAT_W1C: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == A_STAT && wdata[i] && !hit[i]) |=> !stat[i]);  // R5
        AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
            (stat[i] && !(wr_en && addr == A_STAT && wdata[i])) |=> stat[i]);  // R5
    end
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .gen_en (gen_en),
    .cnt    (cnt_q),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .stat   (stat_v),
    .hit    (ch_hit)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
    import evt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NCH-1:0]    irq;

    int   checks = 0, errors = 0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } exp_t;
    exp_t q[$];

    evt_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: pops one expected item per completed read
    always @(negedge clk) begin
        exp_t e;
        if (rd_seen) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R11 read with no expected item, actual %h", rdata);
            end else begin
                e = q.pop_front();
                if (rdata !== e.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", e.tag, rdata, e.exp);
                end
            end
        end
    end

    function automatic logic [ADDR_W-1:0] cfg_ad(int i);
        return 10'h100 + ADDR_W'(i * 32);
    endfunction
    function automatic logic [ADDR_W-1:0] cmp_ad(int i);
        return 10'h108 + ADDR_W'(i * 32);
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
        q.push_back('{e, tag});
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input logic [NCH-1:0] act, input logic [NCH-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        wr(A_GCFG, 64'd0);
        for (int i = 0; i < NCH; i++) begin
            wr(cfg_ad(i), 64'd0);
            wr(cmp_ad(i), '1);
        end
        wr(A_STAT, '1);
        wr(A_CNT, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run hung");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // reset state and map
        rd(A_CAP, {32'd10_000_000, 32'h0000_0102}, "R1 capability word");
        rd(A_GCFG, 64'd0, "R2 control reset");
        rd(A_CNT, 64'd0, "R2 counter reset");
        rd(cfg_ad(0), 64'h20, "R11 ch0 config at 0x100");
        rd(cfg_ad(2), 64'h0, "R9 ch2 no periodic capability");

        // counter load / lock
        wr(A_CNT, 64'd100);
        rd(A_CNT, 64'd100, "R3 load while stopped");
        wr(A_GCFG, 64'd1);
        wr(A_CNT, 64'd5);
        wr(A_GCFG, 64'd0);
        rd(A_CNT, 64'd102, "R3 write ignored while counting");
        idle(5);
        rd(A_CNT, 64'd102, "R2 hold while stopped");

        // one-shot level, status without enable
        quiet();
        wr(cfg_ad(0), 64'h3);
        wr(cfg_ad(1), 64'h2);
        wr(cmp_ad(0), 64'd10);
        wr(cmp_ad(1), 64'd10);
        wr(A_GCFG, 64'd1);
        idle(10);
        chk(irq, 3'b000, "R4 no hit before match");
        idle(1);
        chk(irq, 3'b001, "R6 level irq gated by enable");
        rd(A_STAT, 64'd3, "R6 status set with enable off");
        wr(A_STAT, 64'd0);
        chk(irq, 3'b001, "R5 zero write leaves status");
        wr(A_STAT, 64'd1);
        chk(irq, 3'b000, "R5 one clears status");
        idle(20);
        chk(irq, 3'b000, "R4 one-shot fires once");
        rd(A_STAT, 64'd2, "R5 other bit untouched");

        // hit and clear on the same edge
        quiet();
        wr(cfg_ad(0), 64'h3);
        wr(cmp_ad(0), 64'd4);
        wr(A_GCFG, 64'd1);
        idle(4);
        wr(A_STAT, 64'd1);
        chk(irq, 3'b001, "R5 set wins over clear");

        // edge mode
        quiet();
        wr(cfg_ad(2), 64'h1);
        wr(cmp_ad(2), 64'd6);
        wr(A_GCFG, 64'd1);
        idle(6);
        chk(irq, 3'b000, "R7 before pulse");
        idle(1);
        chk(irq, 3'b100, "R7 pulse on hit");
        idle(1);
        chk(irq, 3'b000, "R7 pulse lasts one clock");
        rd(A_STAT, 64'd0, "R7 no status in edge mode");

        // periodic
        quiet();
        wr(cfg_ad(0), 64'hF);
        wr(cmp_ad(0), 64'd5);
        wr(cmp_ad(0), 64'd8);
        rd(cfg_ad(0), 64'h27, "R8 value-set self clears");
        wr(A_GCFG, 64'd1);
        idle(5);
        chk(irq, 3'b000, "R8 before first hit");
        idle(1);
        chk(irq, 3'b001, "R8 first hit");
        wr(A_STAT, 64'd1);
        chk(irq, 3'b000, "R8 cleared");
        idle(6);
        chk(irq, 3'b000, "R8 before second hit");
        idle(1);
        chk(irq, 3'b001, "R8 second hit one period later");
        rd(cmp_ad(0), 64'd21, "R8 match point advanced");

        // no periodic capability
        quiet();
        wr(cfg_ad(2), 64'hF);
        rd(cfg_ad(2), 64'h3, "R9 periodic bits read zero");
        wr(cmp_ad(2), 64'd4);
        wr(cmp_ad(2), 64'd9);
        wr(A_GCFG, 64'd1);
        idle(5);
        chk(irq, 3'b000, "R9 first write replaced");
        idle(5);
        chk(irq, 3'b100, "R9 second write is match point");
        wr(A_STAT, 64'd4);
        idle(20);
        chk(irq, 3'b000, "R9 no reload");

        // forced 32-bit mode
        quiet();
        wr(A_CNT, 64'h0000_0005_0000_0000);
        wr(cfg_ad(1), 64'h13);
        wr(cmp_ad(1), 64'h0000_0007_0000_0006);
        rd(cmp_ad(1), 64'd6, "R10 upper half dropped");
        wr(A_GCFG, 64'd1);
        idle(6);
        chk(irq, 3'b000, "R10 before low-half match");
        idle(1);
        chk(irq, 3'b010, "R10 low-half match");

        idle(3);
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11 %0d reads never returned, expected 0", q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule